// File: doc/BRIEF.md
# UART Miscellaneous Command Decoder

This block sits in the control section of a UART. Software writes a 3-bit command code through a plain register write strobe. The block turns that code into single-cycle actions on the UART's control and status state. It owns the mode-register pointer, the receiver and transmitter enables, the receive-side flags (character ready, FIFO full) and the transmit-side flags (transmitter empty, ready for data). It also owns four receive error flags and a break-change interrupt flag. It drives a one-cycle reset strobe to the receive FIFO and another to the transmitter. It passes the break start and break stop requests on to the transmitter as one-cycle strobes.

Each command clears only its own subset of state. The receiver and transmitter resets also force the matching enable off, so the path is in a known state before it is reconfigured. The serial shifter, the baud generator and the FIFO storage are outside the block. Their effects reach the block as one-cycle set pulses. The command port is a control register write with no back-pressure: a write is taken on every clock edge where `cmd_we` is high.

Top module: `uart_misc_cmd_ctrl`

## Requirements
- R1: Command codes are decoded as follows: 000 no operation, 001 reset mode pointer, 010 reset receiver, 011 reset transmitter, 100 reset error flags, 101 reset break-change flag, 110 start break, 111 stop break. A command written with `cmd_we` high at a clock edge takes effect on that same edge, so the registered outputs show the result in the following cycle. At most one of the four strobes is high in any cycle.
- R2: The mode pointer is 0 after reset. Each `mode_access` pulse advances it by one until it reaches the last mode register (1 by default), where it holds. Code 001 returns it to 0, and this takes priority over a same-cycle `mode_access`.
- R3: Code 010 clears `rx_en`, `rx_rdy` and `rx_full` and gives a one-cycle `rx_fifo_rst` pulse. The clear takes priority over same-cycle `rx_en_set`, `rx_rdy_set` and `rx_full_set`.
- R4: Code 011 clears `tx_en`, `tx_empty` and `tx_rdy` and gives a one-cycle `tx_rst` pulse. The clear takes priority over same-cycle transmitter set pulses.
- R5: Code 100 clears all four error flags together. The bit order of `err_flags` is [3] received break, [2] framing, [1] parity, [0] overrun.
- R6: A high bit of `err_set` sets the matching error flag, which then stays set. A set pulse wins over a same-cycle code 100 for that bit.
- R7: Code 101 clears only `dbrk_flag`. `dbrk_set` sets it, and a set pulse wins over a same-cycle code 101.
- R8: Code 110 gives a one-cycle `brk_start` pulse only if `tx_en` is high when the command is written. Otherwise the command has no effect.
- R9: Code 111 gives a one-cycle `brk_stop` pulse whatever the state of the enables.
- R10: No command changes state outside its own subset. Code 000 changes nothing.
- R11: `rx_en_set`, `tx_en_set`, `rx_rdy_set`, `rx_full_set`, `tx_empty_set` and `tx_rdy_set` each set their own bit, which stays set until the matching reset command.
- R12: After reset every flag, enable, strobe and the mode pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 3 | Command code |
| mode_access | input | 1 | Pulse: a mode register was accessed |
| rx_en_set | input | 1 | Pulse: enable receiver |
| tx_en_set | input | 1 | Pulse: enable transmitter |
| rx_rdy_set | input | 1 | Pulse: a received character is available |
| rx_full_set | input | 1 | Pulse: the receive FIFO became full |
| tx_empty_set | input | 1 | Pulse: the transmitter ran empty |
| tx_rdy_set | input | 1 | Pulse: the transmit holding register can accept data |
| err_set | input | 4 | Pulses: break, framing, parity, overrun detected |
| dbrk_set | input | 1 | Pulse: the break state changed |
| mode_ptr | output | 1 | Mode register pointer |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rx_rdy | output | 1 | Receive character ready flag |
| rx_full | output | 1 | Receive FIFO full flag |
| tx_empty | output | 1 | Transmitter empty flag |
| tx_rdy | output | 1 | Transmitter ready flag |
| err_flags | output | 4 | Sticky error flags |
| dbrk_flag | output | 1 | Break-change interrupt flag |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset strobe |
| tx_rst | output | 1 | One-cycle transmitter reset strobe |
| brk_start | output | 1 | One-cycle start-break strobe |
| brk_stop | output | 1 | One-cycle stop-break strobe |

## Verification
The bench first sets every flag and enable, then issues each command code. Because all the state is already set, a command that clears too much or too little shows up in the unrelated bits, which separates one subset from another. Set pulses arrive in the same cycle as the clearing command, so the set-wins rule of the error and break-change flags can be told apart from the reset-wins rule of the receiver and transmitter state. Break start is issued with the transmitter enabled and with it disabled, and the mode pointer is advanced past its last value and cleared while an access is pending.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int CMD_W = 3;
  localparam int ERR_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 3'b000,
    CMD_RST_PTR   = 3'b001,
    CMD_RST_RX    = 3'b010,
    CMD_RST_TX    = 3'b011,
    CMD_RST_ERR   = 3'b100,
    CMD_RST_DBRK  = 3'b101,
    CMD_BRK_START = 3'b110,
    CMD_BRK_STOP  = 3'b111
  } misc_cmd_e;

  typedef struct packed {
    logic rst_ptr;
    logic rst_rx;
    logic rst_tx;
    logic rst_err;
    logic rst_dbrk;
    logic brk_start;
    logic brk_stop;
  } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic             we,
  input  logic [CMD_W-1:0] code,
  output cmd_act_t         act
);

  always_comb begin
    act = '0;
    if (we) begin
      case (misc_cmd_e'(code))
        CMD_RST_PTR:   act.rst_ptr   = 1'b1;
        CMD_RST_RX:    act.rst_rx    = 1'b1;
        CMD_RST_TX:    act.rst_tx    = 1'b1;
        CMD_RST_ERR:   act.rst_err   = 1'b1;
        CMD_RST_DBRK:  act.rst_dbrk  = 1'b1;
        CMD_BRK_START: act.brk_start = 1'b1;
        CMD_BRK_STOP:  act.brk_stop  = 1'b1;
        default:       act = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_sticky_flag.sv
// Bank of sticky flags; SET_WINS picks which side wins a same-cycle conflict.
module uart_sticky_flag #(
  parameter int W        = 1,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb q_nxt = (clr ? '0 : q) | set;
    end else begin : g_clr_wins
      always_comb q_nxt = clr ? '0 : (q | set);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/uart_mode_ptr.sv
module uart_mode_ptr #(
  parameter int NUM_REGS = 2,
  parameter int PTR_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                  ptr <= '0;
    else if (clr)                ptr <= '0;
    else if (adv && ptr != LAST) ptr <= ptr + 1'b1;
  end

endmodule

// File: rtl/uart_misc_cmd_ctrl.sv
module uart_misc_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int NUM_MODE_REGS = 2,
  localparam int PTR_W = (NUM_MODE_REGS > 1) ? $clog2(NUM_MODE_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             mode_access,
  input  logic             rx_en_set,
  input  logic             tx_en_set,
  input  logic             rx_rdy_set,
  input  logic             rx_full_set,
  input  logic             tx_empty_set,
  input  logic             tx_rdy_set,
  input  logic [ERR_W-1:0] err_set,
  input  logic             dbrk_set,
  output logic [PTR_W-1:0] mode_ptr,
  output logic             rx_en,
  output logic             tx_en,
  output logic             rx_rdy,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             tx_rdy,
  output logic [ERR_W-1:0] err_flags,
  output logic             dbrk_flag,
  output logic             rx_fifo_rst,
  output logic             tx_rst,
  output logic             brk_start,
  output logic             brk_stop
);

  cmd_act_t act;

  uart_cmd_decode u_dec (
    .we   (cmd_we),
    .code (cmd_code),
    .act  (act)
  );

  uart_mode_ptr #(
    .NUM_REGS (NUM_MODE_REGS),
    .PTR_W    (PTR_W)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (act.rst_ptr),
    .adv   (mode_access),
    .ptr   (mode_ptr)
  );

  // Receiver state: the reset command beats any same-cycle set.
  logic [2:0] rx_q;
  uart_sticky_flag #(.W(3), .SET_WINS(1'b0)) u_rx_state (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({rx_en_set, rx_rdy_set, rx_full_set}),
    .clr   (act.rst_rx),
    .q     (rx_q)
  );
  assign {rx_en, rx_rdy, rx_full} = rx_q;

  // Transmitter state: same rule as the receiver.
  logic [2:0] tx_q;
  uart_sticky_flag #(.W(3), .SET_WINS(1'b0)) u_tx_state (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({tx_en_set, tx_empty_set, tx_rdy_set}),
    .clr   (act.rst_tx),
    .q     (tx_q)
  );
  assign {tx_en, tx_empty, tx_rdy} = tx_q;

  // Receive errors: a fresh event must never be lost to a clear.
  uart_sticky_flag #(.W(ERR_W), .SET_WINS(1'b1)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (act.rst_err),
    .q     (err_flags)
  );

  uart_sticky_flag #(.W(1), .SET_WINS(1'b1)) u_dbrk (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (dbrk_set),
    .clr   (act.rst_dbrk),
    .q     (dbrk_flag)
  );

  // Registered strobes toward the FIFO and the transmitter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_fifo_rst <= 1'b0;
      tx_rst      <= 1'b0;
      brk_start   <= 1'b0;
      brk_stop    <= 1'b0;
    end else begin
      rx_fifo_rst <= act.rst_rx;
      tx_rst      <= act.rst_tx;
      brk_start   <= act.brk_start & tx_en;
      brk_stop    <= act.brk_stop;
    end
  end

endmodule

// File: rtl/uart_misc_cmd_ctrl_chk.sv
module uart_misc_cmd_ctrl_chk
  import uart_cmd_pkg::*;
#(
  parameter int NUM_MODE_REGS = 2,
  parameter int PTR_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_code,
  input logic [ERR_W-1:0] err_set,
  input logic             dbrk_set,
  input logic [PTR_W-1:0] mode_ptr,
  input logic             rx_en,
  input logic             tx_en,
  input logic             rx_rdy,
  input logic             rx_full,
  input logic             tx_empty,
  input logic             tx_rdy,
  input logic [ERR_W-1:0] err_flags,
  input logic             dbrk_flag,
  input logic             rx_fifo_rst,
  input logic             tx_rst,
  input logic             brk_start,
  input logic             brk_stop
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_MODE_REGS - 1);

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_fifo_rst, tx_rst, brk_start, brk_stop}));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_RST_PTR) |=> (mode_ptr == '0));

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ptr == LAST && !(cmd_we && cmd_code == CMD_RST_PTR)) |=> (mode_ptr == LAST));

  p_rx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_RST_RX) |=> (!rx_en && !rx_rdy && !rx_full && rx_fifo_rst));

  p_tx_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_RST_TX) |=> (!tx_en && !tx_empty && !tx_rdy && tx_rst));

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_RST_ERR && err_set == '0) |=> (err_flags == '0));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((err_flags & $past(err_set)) == $past(err_set)));

  p_dbrk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbrk_set |=> dbrk_flag);

  p_brk_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_BRK_START && !tx_en) |=> !brk_start);

  p_brk_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_BRK_STOP) |=> brk_stop);

  p_err_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && cmd_code == CMD_RST_ERR) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

endmodule

bind uart_misc_cmd_ctrl uart_misc_cmd_ctrl_chk #(
  .NUM_MODE_REGS (NUM_MODE_REGS),
  .PTR_W         (PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_we      (cmd_we),
  .cmd_code    (cmd_code),
  .err_set     (err_set),
  .dbrk_set    (dbrk_set),
  .mode_ptr    (mode_ptr),
  .rx_en       (rx_en),
  .tx_en       (tx_en),
  .rx_rdy      (rx_rdy),
  .rx_full     (rx_full),
  .tx_empty    (tx_empty),
  .tx_rdy      (tx_rdy),
  .err_flags   (err_flags),
  .dbrk_flag   (dbrk_flag),
  .rx_fifo_rst (rx_fifo_rst),
  .tx_rst      (tx_rst),
  .brk_start   (brk_start),
  .brk_stop    (brk_stop)
);

// File: tb/test_uart_misc_cmd_ctrl.sv
`timescale 1ns/1ps
module test_uart_misc_cmd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_code = 3'b000;
  logic       mode_access = 1'b0;
  logic       rx_en_set = 1'b0, tx_en_set = 1'b0;
  logic       rx_rdy_set = 1'b0, rx_full_set = 1'b0;
  logic       tx_empty_set = 1'b0, tx_rdy_set = 1'b0;
  logic [3:0] err_set = 4'b0;
  logic       dbrk_set = 1'b0;

  logic       mode_ptr, rx_en, tx_en, rx_rdy, rx_full, tx_empty, tx_rdy;
  logic [3:0] err_flags;
  logic       dbrk_flag, rx_fifo_rst, tx_rst, brk_start, brk_stop;

  always #4 clk = ~clk;

  uart_misc_cmd_ctrl i_uart_misc_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .mode_access(mode_access), .rx_en_set(rx_en_set), .tx_en_set(tx_en_set),
    .rx_rdy_set(rx_rdy_set), .rx_full_set(rx_full_set),
    .tx_empty_set(tx_empty_set), .tx_rdy_set(tx_rdy_set),
    .err_set(err_set), .dbrk_set(dbrk_set),
    .mode_ptr(mode_ptr), .rx_en(rx_en), .tx_en(tx_en), .rx_rdy(rx_rdy),
    .rx_full(rx_full), .tx_empty(tx_empty), .tx_rdy(tx_rdy),
    .err_flags(err_flags), .dbrk_flag(dbrk_flag), .rx_fifo_rst(rx_fifo_rst),
    .tx_rst(tx_rst), .brk_start(brk_start), .brk_stop(brk_stop)
  );

  wire [15:0] observed = {mode_ptr, rx_en, tx_en, rx_rdy, rx_full, tx_empty, tx_rdy,
                          err_flags, dbrk_flag, rx_fifo_rst, tx_rst, brk_start, brk_stop};

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // Expected state, kept from the requirements.
  logic       m_ptr, m_rxen, m_txen, m_rxrdy, m_rxfull, m_txemp, m_txrdy, m_dbrk;
  logic [3:0] m_err;

  // Staged stimulus for the next step.
  logic       s_we, s_acc, s_rxen, s_txen, s_rxrdy, s_rxfull, s_txemp, s_txrdy, s_dbrk;
  logic [2:0] s_code;
  logic [3:0] s_err;

  task automatic clear_stage();
    s_we = 0; s_code = 3'b000; s_acc = 0; s_rxen = 0; s_txen = 0; s_rxrdy = 0;
    s_rxfull = 0; s_txemp = 0; s_txrdy = 0; s_err = 4'b0; s_dbrk = 0;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: applies staged inputs for one cycle and queues the expected outputs.
  task automatic step(input string tag);
    logic c_ptr, c_rx, c_tx, c_err, c_dbrk, c_start, c_stop;
    @(negedge clk);
    cmd_we = s_we; cmd_code = s_code; mode_access = s_acc;
    rx_en_set = s_rxen; tx_en_set = s_txen; rx_rdy_set = s_rxrdy; rx_full_set = s_rxfull;
    tx_empty_set = s_txemp; tx_rdy_set = s_txrdy; err_set = s_err; dbrk_set = s_dbrk;
    c_ptr   = s_we && s_code == 3'b001;
    c_rx    = s_we && s_code == 3'b010;
    c_tx    = s_we && s_code == 3'b011;
    c_err   = s_we && s_code == 3'b100;
    c_dbrk  = s_we && s_code == 3'b101;
    c_start = s_we && s_code == 3'b110 && m_txen;
    c_stop  = s_we && s_code == 3'b111;
    if (c_ptr) m_ptr = 1'b0;
    else if (s_acc) m_ptr = 1'b1;
    if (c_rx) begin m_rxen = 0; m_rxrdy = 0; m_rxfull = 0; end
    else begin m_rxen |= s_rxen; m_rxrdy |= s_rxrdy; m_rxfull |= s_rxfull; end
    if (c_tx) begin m_txen = 0; m_txemp = 0; m_txrdy = 0; end
    else begin m_txen |= s_txen; m_txemp |= s_txemp; m_txrdy |= s_txrdy; end
    m_err  = (c_err ? 4'b0 : m_err) | s_err;
    m_dbrk = (c_dbrk ? 1'b0 : m_dbrk) | s_dbrk;
    exp_q.push_back({m_ptr, m_rxen, m_txen, m_rxrdy, m_rxfull, m_txemp, m_txrdy,
                     m_err, m_dbrk, c_rx, c_tx, c_start, c_stop});
    tag_q.push_back(tag);
    clear_stage();
  endtask

  // Monitor: compares each cycle's outputs against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), observed, exp_q.pop_front());
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    m_ptr = 0; m_rxen = 0; m_txen = 0; m_rxrdy = 0; m_rxfull = 0;
    m_txemp = 0; m_txrdy = 0; m_err = 4'b0; m_dbrk = 0;
    clear_stage();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset state", observed, 16'h0000);

    // R11: set every enable and status bit
    s_rxen = 1; s_txen = 1; s_rxrdy = 1; s_rxfull = 1; s_txemp = 1; s_txrdy = 1;
    step("R11 set pulses");
    step("R11 bits stay set");
    // R2: pointer advances once then holds
    s_acc = 1; step("R2 pointer advance");
    s_acc = 1; step("R2 pointer holds at last");
    // R6: error and break-change flags set
    s_err = 4'b1111; s_dbrk = 1; step("R6 errors set");
    // R10: no-op changes nothing
    s_we = 1; s_code = 3'b000; step("R10 nop");
    // R5: clear errors, other state untouched
    s_we = 1; s_code = 3'b100; step("R5 error clear");
    // R6: set wins over clear
    s_err = 4'b1010; step("R6 set two errors");
    s_we = 1; s_code = 3'b100; s_err = 4'b0010; step("R6 set beats clear");
    // R7: break-change clear only touches its flag; then set wins
    s_we = 1; s_code = 3'b101; step("R7 dbrk clear");
    s_we = 1; s_code = 3'b101; s_dbrk = 1; step("R7 set beats clear");
    // R8 / R9: break strobes with transmitter enabled
    s_we = 1; s_code = 3'b110; step("R8 start break enabled");
    step("R8 strobe is one cycle");
    s_we = 1; s_code = 3'b111; step("R9 stop break");
    // R2: pointer reset, including against a same-cycle access
    s_we = 1; s_code = 3'b001; s_acc = 1; step("R2 reset beats access");
    s_acc = 1; step("R2 advance after reset");
    s_we = 1; s_code = 3'b001; step("R2 pointer reset");
    // R3: receiver reset beats same-cycle sets
    s_we = 1; s_code = 3'b010; s_rxen = 1; s_rxrdy = 1; s_rxfull = 1; step("R3 receiver reset");
    step("R3 strobe is one cycle");
    // R4: transmitter reset
    s_we = 1; s_code = 3'b011; s_txen = 1; step("R4 transmitter reset");
    // R8: start break ignored while transmitter disabled
    s_we = 1; s_code = 3'b110; step("R8 start break disabled");
    // R9: stop break still passes with transmitter disabled
    s_we = 1; s_code = 3'b111; step("R9 stop break disabled");
    // R1: back-to-back different commands
    s_rxen = 1; s_txen = 1; step("R1 re-enable");
    s_we = 1; s_code = 3'b011; step("R1 tx reset only");
    s_we = 1; s_code = 3'b010; step("R1 rx reset only");
    step("R1 idle");
    repeat (3) @(negedge clk);
    report();
  end

endmodule